// File: doc/BRIEF.md
# Display Control Register Interface

This block is the register front end of an eight-digit character display, attached to a parallel microprocessor bus as a slave. It samples active-low chip-enable, write-enable and read-enable strobes on the system clock, together with an attribute-select line and a five-bit address, and steers each access either to a per-digit flash attribute memory (one bit per digit) or to a single 8-bit control word.

The control word carries the brightness code, a flash enable, a blink enable and three action/status bits. One of these starts a clear of the flash and character memories, another starts a self test, and the third reports the self-test verdict. Every control write rewrites all fields at once. The self test snapshots the flash memory and then visits one digit per cycle. The test passes only if every visited cell still holds its snapshot value. The decoded brightness, enables, per-digit flash bits and a one-cycle clear strobe for the character memory are driven out continuously.

Top module: `dcr_regif`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge) the brightness code, flash enable, blink enable, clear strobe, all eight flash bits and `rdata` are 0.
- R2: A write is taken only when, at a clock edge, `cs_n`=0, `we_n`=0 and `re_n`=1. A read is taken only when `cs_n`=0, `re_n`=0 and `we_n`=1. The combinations with `we_n` equal to `re_n` change no state.
- R3: A write commits at the first clock edge at which the write condition is seen. Holding the strobes asserted for further cycles commits nothing more, even if `wdata` changes.
- R4: With `attr_sel`=0, `addr[2:0]` selects digit d (0 = leftmost, 7 = rightmost), and `addr[4:3]` is ignored. A write stores `wdata[0]` into `digit_flash[d]` and ignores `wdata[7:1]`.
- R5: With `attr_sel`=1 the control word is addressed only when `addr[4:3]`=2'b10. Any other address with `attr_sel`=1 ignores writes and reads as 0.
- R6: A control write loads `bright_code` from `wdata[2:0]`, `flash_en` from `wdata[3]` and `blink_en` from `wdata[4]` in the same edge, all together. `wdata[5]` is ignored.
- R7: A control write with `wdata[7]`=1 raises `clear_pulse` for exactly the one cycle after the commit edge. All flash bits are 0 from the following edge. Control bit 7 then reads back as 0.
- R8: A control write with `wdata[6]`=1 starts a self test. Control bit 6 reads 1 and bit 5 reads 0 for 8 cycles after the commit edge, then bit 6 returns to 0.
- R9: A self test started at edge E compares the cell of digit k at edge E+1+k against its value at E. Bit 5 reads 1 (pass) if no cell differed and 0 otherwise. A control write with bit 6 = 0 during the test aborts it with bit 5 = 0. A control write with bit 6 = 1 restarts it.
- R10: Read data is registered: `rdata` holds the selected value in the cycle after the read edge and is 0 when no read is taken. A flash read returns {7'b0, cell}. A control read returns {bit 7 clear, bit 6 busy, bit 5 result, bit 4 blink, bit 3 flash, bits 2:0 brightness}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low |
| re_n | input | 1 | Read strobe, active low |
| attr_sel | input | 1 | 0 selects flash attribute memory, 1 selects register space |
| addr | input | 5 | Access address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| bright_code | output | 3 | Brightness code, 0 is full brightness, 7 is blank |
| flash_en | output | 1 | Per-digit flashing enabled |
| blink_en | output | 1 | Whole-display blinking enabled |
| digit_flash | output | 8 | Flash attribute per digit, bit 0 leftmost |
| clear_pulse | output | 1 | One-cycle strobe to clear the character memory |

## Verification
The self-test walk and a bus write to the flash memory can touch the same digit cell in the same cycle. The outcome then depends on whether the write lands at or before the walk's visit to that digit. The bench starts a test, waits a chosen number of idle cycles and flips one digit's cell. It sweeps every digit against a range of write delays, so the write falls before, at and after each visit. The verdict read back from bit 5 is judged against pass exactly when the write edge lies later than E plus the digit index.

// File: rtl/dcr_pkg.sv
// Package: shared types for the display control register interface.
// Assumes an 8-bit control word whose field layout is fixed by bus software.
package dcr_pkg;

    localparam int DATA_W   = 8;
    localparam int BRIGHT_W = 3;

    // Destination of a decoded bus access
    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_FLASH = 2'd1,
        TGT_CTRL  = 2'd2
    } tgt_e;

    // Control word as read back over the bus, most significant field first
    typedef struct packed {
        logic                clr;
        logic                busy;
        logic                result;
        logic                blink;
        logic                flash;
        logic [BRIGHT_W-1:0] bright;
    } ctl_word_t;

endpackage

// File: rtl/dcr_bus_decode.sv
// Module: dcr_bus_decode
// Decodes the bus strobes and address into a one-shot write fire, a read
// level, a target and a digit index.
// Assumes strobes are already synchronous to clk; undefined strobe
// combinations produce neither a read nor a write.
module dcr_bus_decode
    import dcr_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              re_n,
    input  logic              attr_sel,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_fire,
    output logic              rd_act,
    output tgt_e              tgt,
    output logic [IDX_W-1:0]  idx
);

    logic wr_lvl;
    logic wr_prev;

    assign wr_lvl  = !cs_n && !we_n && re_n;
    assign rd_act  = !cs_n && !re_n && we_n;
    assign wr_fire = wr_lvl && !wr_prev;
    assign idx     = addr[IDX_W-1:0];

    // Remember the write level so a held write fires once
    always_ff @(posedge clk) begin
        if (!rst_n) wr_prev <= 1'b0;
        else        wr_prev <= wr_lvl;
    end

    // Map select line and upper address bits to a target
    always_comb begin
        if (!attr_sel)                                tgt = TGT_FLASH;
        else if (addr[ADDR_W-1:ADDR_W-2] == 2'b10)    tgt = TGT_CTRL;
        else                                          tgt = TGT_NONE;
    end

endmodule

// File: rtl/dcr_flash_mem.sv
// Module: dcr_flash_mem
// One flag per digit; a write loads the addressed flag, clear empties all.
// Assumes clear and write never need to merge: clear has priority.
module dcr_flash_mem #(
    parameter int DIGITS = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_bit,
    input  logic              clr,
    output logic [DIGITS-1:0] cells
);

    for (genvar g = 0; g < DIGITS; g++) begin : g_cell
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
        logic cell_q;

        // Hold one digit's flash flag
        always_ff @(posedge clk) begin
            if (!rst_n)                            cell_q <= 1'b0;
            else if (clr)                          cell_q <= 1'b0;
            else if (wr_en && (wr_idx == MY_IDX))  cell_q <= wr_bit;
        end

        assign cells[g] = cell_q;
    end

endmodule

// File: rtl/dcr_ctl_reg.sv
// Module: dcr_ctl_reg
// Control word storage plus the self-test sequencer.
// Assumes DIGITS is a power of two so the walk index wraps naturally.
// Any control write during a test either restarts it (bit 6 = 1) or aborts it.
module dcr_ctl_reg
    import dcr_pkg::*;
#(
    parameter int DIGITS = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DIGITS-1:0] cells,
    output ctl_word_t         word
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DIGITS - 1);

    logic [BRIGHT_W-1:0] br_q;
    logic                fl_q;
    logic                bl_q;
    logic                clr_q;
    logic                busy_q;
    logic                res_q;
    logic                ok_q;
    logic [IDX_W-1:0]    step_q;
    logic [DIGITS-1:0]   snap_q;
    logic                cell_match;
    logic                unused_result_bit;

    assign unused_result_bit = wdata[5];
    assign cell_match        = (cells[step_q] == snap_q[step_q]);

    // Plain fields: all rewritten per write; clear bit self-clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            br_q  <= '0;
            fl_q  <= 1'b0;
            bl_q  <= 1'b0;
            clr_q <= 1'b0;
        end else if (wr_en) begin
            br_q  <= wdata[BRIGHT_W-1:0];
            fl_q  <= wdata[3];
            bl_q  <= wdata[4];
            clr_q <= wdata[7];
        end else begin
            clr_q <= 1'b0;
        end
    end

    // Self test: snapshot, then compare one digit per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            res_q  <= 1'b0;
            ok_q   <= 1'b0;
            step_q <= '0;
            snap_q <= '0;
        end else if (wr_en && wdata[6]) begin
            busy_q <= 1'b1;
            res_q  <= 1'b0;
            ok_q   <= 1'b1;
            step_q <= '0;
            snap_q <= cells;
        end else if (wr_en && busy_q) begin
            busy_q <= 1'b0;
            res_q  <= 1'b0;
        end else if (busy_q) begin
            step_q <= step_q + 1'b1;
            if (step_q == LAST) begin
                busy_q <= 1'b0;
                res_q  <= ok_q && cell_match;
            end else begin
                ok_q   <= ok_q && cell_match;
            end
        end
    end

    assign word = '{clr: clr_q, busy: busy_q, result: res_q,
                    blink: bl_q, flash: fl_q, bright: br_q};

endmodule

// File: rtl/dcr_regif.sv
// Module: dcr_regif (top)
// Bus slave for an eight-digit display: decodes accesses, holds the flash
// attribute memory and control word, registers read data.
// Assumes bus strobes are synchronous to clk.
module dcr_regif
    import dcr_pkg::*;
#(
    parameter int DIGITS = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              re_n,
    input  logic              attr_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [2:0]        bright_code,
    output logic              flash_en,
    output logic              blink_en,
    output logic [DIGITS-1:0] digit_flash,
    output logic              clear_pulse
);

    localparam int IDX_W = $clog2(DIGITS);

    logic             wr_fire;
    logic             rd_act;
    tgt_e             tgt;
    logic [IDX_W-1:0] idx;
    ctl_word_t        word;

    dcr_bus_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .re_n(re_n),
        .attr_sel(attr_sel), .addr(addr),
        .wr_fire(wr_fire), .rd_act(rd_act), .tgt(tgt), .idx(idx)
    );

    dcr_flash_mem #(.DIGITS(DIGITS), .IDX_W(IDX_W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_fire && (tgt == TGT_FLASH)), .wr_idx(idx),
        .wr_bit(wdata[0]), .clr(word.clr), .cells(digit_flash)
    );

    dcr_ctl_reg #(.DIGITS(DIGITS), .IDX_W(IDX_W)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_fire && (tgt == TGT_CTRL)), .wdata(wdata),
        .cells(digit_flash), .word(word)
    );

    // Register the selected read value; zero when no read is taken
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_act) begin
            case (tgt)
                TGT_FLASH: rdata <= {{(DATA_W-1){1'b0}}, digit_flash[idx]};
                TGT_CTRL:  rdata <= word;
                default:   rdata <= '0;
            endcase
        end else         rdata <= '0;
    end

    assign bright_code = word.bright;
    assign flash_en    = word.flash;
    assign blink_en    = word.blink;
    assign clear_pulse = word.clr;

endmodule

// File: rtl/dcr_regif_chk.sv
// Module: dcr_regif_chk
// Temporal checks on the ports of dcr_regif, bound into every instance.
module dcr_regif_chk #(
    parameter int DIGITS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              we_n,
    input logic              re_n,
    input logic [7:0]        rdata,
    input logic [2:0]        bright_code,
    input logic              flash_en,
    input logic              blink_en,
    input logic [DIGITS-1:0] digit_flash,
    input logic              clear_pulse
);

    logic wr_c;
    logic rd_c;
    logic wr_seen;

    assign wr_c = !cs_n && !we_n && re_n;
    assign rd_c = !cs_n && !re_n && we_n;

    // Track the write level of the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) wr_seen <= 1'b0;
        else        wr_seen <= wr_c;
    end

    assert_ctl_hold_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_c |=> ($stable(bright_code) && $stable(flash_en) && $stable(blink_en)));

    assert_single_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_c && wr_seen) |=> ($stable(bright_code) && $stable(flash_en) && $stable(blink_en)));

    assert_flash_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_c && !clear_pulse) |=> $stable(digit_flash));

    assert_clear_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_pulse |=> !clear_pulse);

    assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_pulse |=> (digit_flash == '0));

    assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_c |=> (rdata == 8'h00));

endmodule

bind dcr_regif dcr_regif_chk #(.DIGITS(DIGITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .re_n(re_n),
    .rdata(rdata), .bright_code(bright_code), .flash_en(flash_en),
    .blink_en(blink_en), .digit_flash(digit_flash), .clear_pulse(clear_pulse)
);

// File: tb/dcr_regif_bench.sv
// Bench for dcr_regif: sweeps strobes, addresses, control values and
// self-test collision timing; expected values are computed here.
module dcr_regif_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       we_n = 1'b1;
    logic       re_n = 1'b1;
    logic       attr_sel = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [2:0] bright_code;
    logic       flash_en;
    logic       blink_en;
    logic [7:0] digit_flash;
    logic       clear_pulse;

    int   n_cmp = 0;
    int   n_bad = 0;
    logic pulse_seen;
    logic finished = 1'b0;

    always #10 clk = ~clk;

    dcr_regif u_dcr_regif (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .re_n(re_n),
        .attr_sel(attr_sel), .addr(addr), .wdata(wdata), .rdata(rdata),
        .bright_code(bright_code), .flash_en(flash_en), .blink_en(blink_en),
        .digit_flash(digit_flash), .clear_pulse(clear_pulse)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        cs_n = 1'b1; we_n = 1'b1; re_n = 1'b1;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic cyc(input logic c, input logic w, input logic r,
                       input logic fl, input logic [4:0] a, input logic [7:0] d);
        cs_n = c; we_n = w; re_n = r; attr_sel = fl; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        pulse_seen = clear_pulse;
        idle();
    endtask

    task automatic wr(input logic fl, input logic [4:0] a, input logic [7:0] d);
        cyc(1'b0, 1'b0, 1'b1, fl, a, d);
    endtask

    task automatic rd(input logic fl, input logic [4:0] a, output logic [7:0] q);
        cs_n = 1'b0; we_n = 1'b1; re_n = 1'b0; attr_sel = fl; addr = a;
        @(posedge clk); @(negedge clk);
        q = rdata;
        idle();
    endtask

    localparam logic [4:0] CTL = 5'b10000;

    initial begin
        logic [7:0] got;
        logic [7:0] model;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 bright", {5'b0, bright_code}, 8'h00);
        check("R1 flags", {5'b0, flash_en, blink_en, clear_pulse}, 8'h00);
        check("R1 flash", digit_flash, 8'h00);
        check("R1 rdata", rdata, 8'h00);
        rst_n = 1'b1;
        idle();

        // R6 all field values, bit 5 ignored; R10 readback layout
        for (int v = 0; v < 32; v++) begin
            wr(1'b1, CTL, {2'b00, v[0], 5'(v)});
            check("R6 bright", {5'b0, bright_code}, {5'b0, 3'(v)});
            check("R6 enables", {6'b0, blink_en, flash_en}, {6'b0, 2'(v >> 3)});
            rd(1'b1, CTL, got);
            check("R10 ctl read", got, {3'b000, 5'(v)});
        end

        // R2 every strobe combination, control and flash targets
        for (int k = 0; k < 8; k++) begin
            wr(1'b1, CTL, 8'h00);
            cyc(k[2], k[1], k[0], 1'b1, CTL, 8'h1D);
            check("R2 ctl combo", {3'b0, blink_en, flash_en, bright_code},
                  (k == 1) ? 8'h1D : 8'h00);
            cyc(k[2], k[1], k[0], 1'b0, 5'b00000, 8'h01);
            check("R2 flash combo", digit_flash, (k == 1) ? 8'h01 : 8'h00);
            wr(1'b0, 5'b00000, 8'h00);
        end

        // R3 held write commits once
        cs_n = 1'b0; we_n = 1'b0; re_n = 1'b1; attr_sel = 1'b1; addr = CTL; wdata = 8'h03;
        @(posedge clk); @(negedge clk); wdata = 8'h06;
        @(posedge clk); @(negedge clk); wdata = 8'h17;
        @(posedge clk); @(negedge clk);
        idle();
        check("R3 held write", {5'b0, bright_code}, 8'h03);
        check("R3 held enables", {6'b0, blink_en, flash_en}, 8'h00);

        // R5 non-control register addresses
        wr(1'b1, CTL, 8'h00);
        for (int a = 0; a < 32; a++) begin
            if (a[4:3] != 2'b10) begin
                wr(1'b1, 5'(a), 8'h1F);
                check("R5 ignored write", {3'b0, blink_en, flash_en, bright_code}, 8'h00);
                rd(1'b1, 5'(a), got);
                check("R5 read zero", got, 8'h00);
            end
        end

        // R4 flash addressing with don't-care address and data bits
        model = 8'h00;
        for (int p = 0; p < 2; p++) begin
            for (int d = 0; d < 8; d++) begin
                logic bitv;
                bitv = (p == 0) ? 1'(8'hA5 >> d) : 1'(8'h5A >> d);
                wr(1'b0, {2'(d * 3 + p), 3'(d)}, {7'(8'h55 ^ d), bitv});
                model[d] = bitv;
                check("R4 digit_flash", digit_flash, model);
            end
            for (int d = 0; d < 8; d++) begin
                rd(1'b0, {2'(d + p), 3'(d)}, got);
                check("R10 flash read", got, {7'b0, model[d]});
            end
        end

        // R7 clear action
        for (int d = 0; d < 8; d++) wr(1'b0, 5'(d), 8'h01);
        wr(1'b1, CTL, 8'h82);
        check("R7 pulse after commit", {7'b0, pulse_seen}, 8'h01);
        check("R7 pulse dropped", {7'b0, clear_pulse}, 8'h00);
        check("R7 flash cleared", digit_flash, 8'h00);
        rd(1'b1, CTL, got);
        check("R7 bit7 reads 0", got, 8'h02);
        wr(1'b1, CTL, 8'h00);

        // R8 busy window and pass with no disturbance
        wr(1'b1, CTL, 8'h60);
        rd(1'b1, CTL, got);
        check("R8 busy during test", got, 8'h40);
        repeat (10) idle();
        rd(1'b1, CTL, got);
        check("R8 done and passed", got, 8'h20);

        // R9 abort by a control write with bit 6 = 0
        wr(1'b1, CTL, 8'h40);
        wr(1'b1, CTL, 8'h00);
        repeat (10) idle();
        rd(1'b1, CTL, got);
        check("R9 abort fails", got, 8'h00);

        // R9 restart extends busy past the original end
        wr(1'b1, CTL, 8'h40);
        wr(1'b1, CTL, 8'h40);
        repeat (5) idle();
        rd(1'b1, CTL, got);
        check("R9 restart still busy", got, 8'h40);
        repeat (10) idle();
        rd(1'b1, CTL, got);
        check("R9 restart passes", got, 8'h20);

        // R9 same-value write during walk leaves pass
        wr(1'b1, CTL, 8'h40);
        wr(1'b0, 5'd3, 8'h00);
        repeat (10) idle();
        rd(1'b1, CTL, got);
        check("R9 same value write", got, 8'h20);

        // R9 collision sweep: flip digit d at edge E+2+j
        for (int d = 0; d < 8; d++) begin
            for (int j = 0; j < 6; j++) begin
                wr(1'b1, CTL, 8'h40);
                repeat (j) idle();
                wr(1'b0, 5'(d), 8'h01);
                repeat (10) idle();
                rd(1'b1, CTL, got);
                check($sformatf("R9 digit %0d delay %0d", d, j), got,
                      (j + 2 > d) ? 8'h20 : 8'h00);
                wr(1'b0, 5'(d), 8'h00);
            end
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule